// File: doc/BRIEF.md
# Linked-List Summing Processor

The block walks a singly linked list kept in an external single-ported memory and adds up the signed 8-bit values stored in its nodes. A node takes two consecutive bytes: the byte at the node's own address holds the address of the next node, and the byte one address higher holds the node's value. Nodes may start at odd or even addresses. The list always begins at address 0 and has at least one node. A next-node address of 0 marks the final node.

A one-cycle `start` pulse begins a walk from address 0. The memory answers combinationally and allows one access per cycle, so each node takes two cycles. In the first cycle the block reads the value and adds it to the running sum. In the second cycle it reads the link and, with the same shared adder, works out the address of the next node's value. When the link read back is 0, the block copies the sum to `r` and raises `done`. Both then hold until the next `start`.

Top module: `llsum_top`

## Requirements
- R1: While reset is high, and after it is released with no `start`, `done` is 0 and `r` is 0.
- R2: `done` is 0 in the cycle after a `start` edge and stays 0 for every cycle of the walk.
- R3: When `done` rises, `r` equals the sum of every node value in the list, each value taken as an 8-bit two's complement integer.
- R4: For a node at address A, `mem[A]` is the next node address and `mem[A+1]` is the value. A may be odd. The walk ends at the first node whose next address is 0.
- R5: For a list of N nodes, `done` rises exactly 2N cycles after the clock edge that samples `start`.
- R6: In the first cycle of each node visit, `mem_addr` equals the node address plus 1. In the second cycle it equals the node address. The walk begins with the node at address 0.
- R7: Once `done` is 1, `done` and `r` keep their values until the next `start`, whatever the memory returns.
- R8: A `start` during a walk abandons that walk and begins a new one from address 0. The new result depends only on the list read after the restart.
- R9: The sum wraps modulo 256 with no overflow indication.
- R10: A list with a single node (`mem[0]` = 0) finishes in 2 cycles, with `r` = `mem[1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that begins (or restarts) a walk at address 0 |
| mem_addr | output | W (8) | Address presented to the external memory |
| mem_rdata | input | W (8) | Combinational read data for `mem_addr` |
| done | output | 1 | Walk complete; held until the next `start` |
| r | output | W (8) | Final sum; held until the next `start` |

## Verification
The hardest case to reach from the ports is a restart in the middle of a walk, after the link and value-address registers already point deep into the list. Reaching it needs a long list and a second `start` pulse timed to arrive mid-walk. The bench rewrites the memory at that same edge, so any state left over from the first walk would show up as a wrong address or a wrong sum. The scoreboard flushes its expected addresses at the restart and checks the address sequence of the new walk cycle by cycle. It also checks that the held result ignores memory contents changed after `done`.

// File: rtl/llsum_pkg.sv
package llsum_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_LINK = 2'd2
  } llsum_state_e;
endpackage

// File: rtl/llsum_shared_adder.sv
module llsum_shared_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] sum_y
);
  // Carry out is dropped on purpose: the result wraps modulo 2**W.
  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[W-1:0];
  endfunction

  assign sum_y = wrap_add(op_a, op_b);
endmodule

// File: rtl/llsum_ctrl.sv
module llsum_ctrl
  import llsum_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic link_zero,
  output logic phase_acc,
  output logic phase_link,
  output logic finish,
  output logic done
);
  llsum_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (start) begin
      state_d = ST_ACC;
    end else begin
      case (state_q)
        ST_ACC:  state_d = ST_LINK;
        ST_LINK: state_d = link_zero ? ST_IDLE : ST_ACC;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start)       done <= 1'b0;
      else if (finish) done <= 1'b1;
    end
  end

  assign phase_acc  = (state_q == ST_ACC);
  assign phase_link = (state_q == ST_LINK);
  assign finish     = phase_link && link_zero;
endmodule

// File: rtl/llsum_dp.sv
module llsum_dp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         phase_acc,
  input  logic         phase_link,
  input  logic         finish,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] mem_addr,
  output logic         link_zero,
  output logic [W-1:0] r,
  output logic [W-1:0] ptr_q,
  output logic [W-1:0] numa_q,
  output logic [W-1:0] sum_q
);
  localparam logic [W-1:0] HEAD_ADDR = '0;
  localparam logic [W-1:0] VAL_OFS   = W'(1);
  localparam logic [W-1:0] END_MARK  = '0;

  logic [W-1:0] op_a, add_y;

  // Operand mux for the one adder: running sum in the value cycle, +1 in the link cycle.
  assign op_a = phase_acc ? sum_q : VAL_OFS;

  llsum_shared_adder #(.W(W)) u_add (
    .op_a  (op_a),
    .op_b  (mem_rdata),
    .sum_y (add_y)
  );

  assign mem_addr  = phase_acc ? numa_q : ptr_q;
  assign link_zero = (mem_rdata == END_MARK);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= HEAD_ADDR;
      numa_q <= HEAD_ADDR + VAL_OFS;
      sum_q  <= '0;
      r      <= '0;
    end else if (clr) begin
      ptr_q  <= HEAD_ADDR;
      numa_q <= HEAD_ADDR + VAL_OFS;
      sum_q  <= '0;
    end else begin
      if (phase_acc) sum_q <= add_y;
      if (phase_link) begin
        ptr_q  <= mem_rdata;
        numa_q <= add_y;
      end
      if (finish) r <= sum_q;
    end
  end
endmodule

// File: rtl/llsum_top.sv
module llsum_top #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata,
  output logic         done,
  output logic [W-1:0] r
);
  logic         phase_acc, phase_link, finish, link_zero;
  logic [W-1:0] ptr_q, numa_q, sum_q;

  llsum_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .link_zero  (link_zero),
    .phase_acc  (phase_acc),
    .phase_link (phase_link),
    .finish     (finish),
    .done       (done)
  );

  llsum_dp #(.W(W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .clr        (start),
    .phase_acc  (phase_acc),
    .phase_link (phase_link),
    .finish     (finish),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .link_zero  (link_zero),
    .r          (r),
    .ptr_q      (ptr_q),
    .numa_q     (numa_q),
    .sum_q      (sum_q)
  );
endmodule

// File: rtl/llsum_chk.sv
module llsum_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         done,
  input logic [W-1:0] r,
  input logic [W-1:0] mem_rdata,
  input logic         phase_acc,
  input logic         phase_link,
  input logic [W-1:0] ptr_q,
  input logic [W-1:0] numa_q
);
  a_r2_start_clears_done: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);

  a_r8_restart_at_head: assert property (@(posedge clk) disable iff (rst)
    start |=> phase_acc && ptr_q == '0 && numa_q == W'(1));

  a_r5_value_then_link: assert property (@(posedge clk) disable iff (rst)
    (phase_acc && !start) |=> phase_link);

  a_r6_numa_follows_ptr: assert property (@(posedge clk) disable iff (rst)
    (phase_link && !start) |=> numa_q == ptr_q + W'(1));

  a_r4_stop_on_zero: assert property (@(posedge clk) disable iff (rst)
    (phase_link && !start && mem_rdata == '0) |=> done && !phase_acc);

  a_r4_continue_on_link: assert property (@(posedge clk) disable iff (rst)
    (phase_link && !start && mem_rdata != '0) |=> phase_acc && !done);

  a_r7_result_held: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done && $stable(r));

  a_r1_phases_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({phase_acc, phase_link}));
endmodule

bind llsum_top llsum_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .done       (done),
  .r          (r),
  .mem_rdata  (mem_rdata),
  .phase_acc  (phase_acc),
  .phase_link (phase_link),
  .ptr_q      (ptr_q),
  .numa_q     (numa_q)
);

// File: tb/llsum_top_tb.sv
module llsum_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] mem_addr, mem_rdata;
  logic       done;
  logic [7:0] r;

  logic [7:0] mem [0:255];
  assign mem_rdata = mem[mem_addr];

  always #2 clk = ~clk;

  llsum_top #(.W(8)) u_dut (
    .clk(clk), .rst(rst), .start(start),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .r(r)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  logic [7:0] exp_r;
  bit         armed = 0;
  bit         pending = 0;
  logic [7:0] node_addr [0:15];
  logic [7:0] node_val  [0:15];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Fill memory with noise, lay out the nodes, and work out the expected result.
  task automatic build(input int n);
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    exp_r = 8'd0;
    for (int k = 0; k < n; k++) begin
      mem[node_addr[k]]        = (k == n - 1) ? 8'd0 : node_addr[k+1];
      mem[node_addr[k] + 8'd1] = node_val[k];
      exp_r = exp_r + node_val[k];
    end
  endtask

  // Driver: rewrite memory, pulse start, and push the expected address sequence.
  task automatic launch(input int n);
    @(posedge clk); #1;
    armed = 0; pending = 0; exp_q.delete();
    build(n);
    start = 1'b1;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(node_addr[k] + 8'd1);
      exp_q.push_back(node_addr[k]);
    end
    @(posedge clk); #1;
    start = 1'b0;
    armed = 1;
  endtask

  task automatic wait_done();
    while (armed || pending) @(negedge clk);
  endtask

  // Monitor: one expected address per walk cycle, then the result one cycle after the last.
  always @(negedge clk) begin
    if (pending) begin
      chk(done === 1'b1, "R5 done after 2N cycles", int'(done), 1);
      chk(r === exp_r, "R3 final sum", int'(r), int'(exp_r));
      pending = 0;
    end else if (armed && exp_q.size() > 0) begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(mem_addr === e, "R6 address sequence", int'(mem_addr), int'(e));
      chk(done === 1'b0, "R2 done low during walk", int'(done), 0);
      if (exp_q.size() == 0) begin
        armed = 0;
        pending = 1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0 && r === 8'd0, "R1 state in reset", int'(r), 0);
    @(posedge clk); #1 rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R1 done low after reset", int'(done), 0);
    chk(r === 8'd0, "R1 r zero after reset", int'(r), 0);

    // R10: single node
    node_addr[0] = 8'd0; node_val[0] = 8'hFB;
    launch(1); wait_done();
    chk(r === 8'hFB, "R10 single node", int'(r), 251);

    // R4: odd node addresses
    node_addr[0] = 8'd0;   node_val[0] = 8'd10;
    node_addr[1] = 8'd37;  node_val[1] = 8'hFD;
    node_addr[2] = 8'd101; node_val[2] = 8'd50;
    launch(3); wait_done();
    chk(r === 8'd57, "R4 odd addresses", int'(r), 57);

    // R9: positive overflow wraps
    for (int k = 0; k < 4; k++) begin
      node_addr[k] = 8'(2 * k); node_val[k] = 8'd100;
    end
    launch(4); wait_done();
    chk(r === 8'd144, "R9 wrap positive", int'(r), 144);

    // R9: negative overflow wraps
    node_addr[0] = 8'd0;  node_val[0] = 8'h80;
    node_addr[1] = 8'd99; node_val[1] = 8'hFF;
    launch(2); wait_done();
    chk(r === 8'h7F, "R9 wrap negative", int'(r), 127);

    // R7: result held while memory changes
    for (int i = 0; i < 256; i++) mem[i] = 8'(255 - i);
    repeat (10) @(negedge clk);
    chk(done === 1'b1, "R7 done held", int'(done), 1);
    chk(r === 8'h7F, "R7 r held", int'(r), 127);

    // R8: abort a long walk mid-way
    for (int k = 0; k < 6; k++) begin
      node_addr[k] = 8'(k * 13 - (k > 0 ? 4 : 0)); node_val[k] = 8'(k + 1);
    end
    launch(6);
    repeat (3) @(negedge clk);
    node_addr[0] = 8'd0;   node_val[0] = 8'd20;
    node_addr[1] = 8'd201; node_val[1] = 8'd22;
    launch(2); wait_done();
    chk(r === 8'd42, "R8 restart result", int'(r), 42);

    // R2: start while done is high clears it
    node_addr[0] = 8'd0; node_val[0] = 8'd5;
    @(negedge clk);
    chk(done === 1'b1, "R2 done before restart", int'(done), 1);
    launch(1); wait_done();
    chk(r === 8'd5, "R3 sum after restart from done", int'(r), 5);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule